// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a programmable interval timer. It has three registers of its own: a control/status register, an up-counter and a compare register. It also holds its own run bit of a start/stop register that several channels share. While the run bit is set, a prescaler turns the system clock into count ticks. On each tick the counter steps up by one. When the counter equals the compare value, the next tick returns it to zero and sets a sticky match flag. The match flag, gated by an enable bit, drives the interrupt output.

The parameter `CNT_W` selects one of two variants. The 16-bit variant has a 16-bit counter and registers spaced 2 bytes apart. The 32-bit variant has a 32-bit counter and compare register spaced 4 bytes apart, a 16-bit control/status register, and a second sticky flag that records a wrap past the counter maximum. Software starts and stops the channel through the shared register, polls or takes the interrupt, and clears flags by writing back control/status with the flag bits at zero.

Top module: `cmt_channel`

## Requirements
- R1: After a synchronous active-low reset, control/status and counter read zero, compare reads all ones, the channel is stopped, and `irq` is low.
- R2: With `bus_shr` low, bits [SHIFT+1:SHIFT] of `bus_addr` give a word index: 0 = control/status, 1 = counter, 2 = compare, 3 = reads zero. SHIFT is 1 in the 16-bit variant and 2 in the 32-bit variant. The address bits below SHIFT are ignored.
- R3: In the 32-bit variant, counter and compare use all 32 data bits. Control/status and the shared register use `bus_wdata[15:0]` and read back with bits [31:16] zero.
- R4: A write with `bus_shr` high sets the channel's run bit from `bus_wdata[CH_IDX]` and ignores every other bit. A read with `bus_shr` high returns the run bit at bit position `CH_IDX`, with all other bits zero.
- R5: One tick occurs every 8·4^k clocks while running, where k is control/status bits [1:0]. On a tick the counter returns to 0 if it equals compare, and increments otherwise. One period is therefore compare+1 ticks.
- R6: A tick at a match sets the match flag. This is bit 7 in the 16-bit variant and bit 15 in the 32-bit variant. In the 32-bit variant, a tick taken at all ones without a match sets flag bit 14. Both flags stay set until cleared.
- R7: A control/status write with a flag bit at 0 clears that flag. Writing 1 to a flag bit has no effect. A match in the same cycle as a clearing write leaves the flag set. The other writable bits are [6:0] in the 16-bit variant and [13:0] in the 32-bit variant, and they read back as written.
- R8: `irq` equals match flag AND interrupt enable. The enable is bit 6 in the 16-bit variant and bit 5 in the 32-bit variant. `irq` stays high until the flag is cleared.
- R9: A counter write loads the counter directly and takes priority over a tick. A compare write is used from the next tick on. If compare is lowered below the count, the counter runs up to all ones and wraps to zero.
- R10: While the run bit is 0, the counter holds its value and the prescaler stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_shr | input | 1 | Selects the shared start/stop register instead of the channel registers |
| bus_addr | input | ADDR_W | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench targets a clearing write that lands in the same cycle as a match. A design that gives the write priority would lose that match, leaving the flag and `irq` low when they should be high. It lowers compare below a loaded count near the maximum. A design that compares with `>=` would wrap at once instead of running on to all ones, and in the 32-bit variant the wrap flag would never set. It also covers a zero compare (a match on every tick), a change of prescale factor, and shared-register writes with other channels' bits set or cleared. A design that decodes the wrong bit of the shared register would start or stop at the wrong time. A design that takes wide writes into the 16-bit register would read back nonzero upper bits.

// File: rtl/cmt_pkg.sv
// Shared types for the compare-match timer channel.
// Assumes: the word index decoded from the bus address is two bits wide.
package cmt_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_MATCH = 2'd2,
        SEL_NONE  = 2'd3
    } cmt_sel_e;

    // Prescale factor for a clock-select code: 8 * 4^code.
    function automatic logic [31:0] tick_div(input logic [1:0] code);
        return 32'd8 << {code, 1'b0};
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
// Prescaler: emits one tick pulse every tick_div(cks) clocks while run is high.
// Assumes: PRE_W holds the largest divisor minus one (511). It clears whenever stopped.
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int PRE_W = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] cks,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic [31:0]      div_full;

    // Terminal count for the selected factor.
    always_comb begin
        div_full = tick_div(cks) - 32'd1;
        lim      = div_full[PRE_W-1:0];
    end

    assign tick = run && (pre_q >= lim);

    // Divider state: cleared when stopped or on a tick, otherwise counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    logic div_unused;
    assign div_unused = ^div_full[31:PRE_W];

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R10
    stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pre_q == '0);

endmodule

// File: rtl/cmt_counter.sv
// Counter and compare register pair. Counts on tick, returns to zero after
// the compare value or after all ones. Reports match and wrap pulses.
// Assumes: a counter load beats a tick in the same cycle.
module cmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             hit,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic step;
    assign step = tick && !cnt_we;
    assign hit  = step && (cnt_q == cmp_q);
    assign wrap = step && (cnt_q != cmp_q) && (cnt_q == TOP);

    // Counter: direct load, or advance with return to zero on match/top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wr_val;
        end else if (tick) begin
            if (cnt_q == cmp_q || cnt_q == TOP) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Compare register: reset to all ones, loaded by write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_we) begin
            cmp_q <= wr_val;
        end
    end

    // R5
    hit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cnt_q == '0);

    // R9
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_q == $past(wr_val));

    // R9
    cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> cmp_q == $past(wr_val));

endmodule

// File: rtl/cmt_ctrl.sv
// Control/status and run-bit logic: writable control field, sticky flags with
// write-zero clear, interrupt gating, and this channel's bit of the shared
// start/stop register.
// Assumes: CH_IDX < 16. The wrap flag exists only when CNT_W is 32.
module cmt_ctrl #(
    parameter int CNT_W  = 16,
    parameter int CH_IDX = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic        shr_we,
    input  logic [15:0] wr16,
    input  logic        hit,
    input  logic        wrap,
    output logic        run,
    output logic [1:0]  cks,
    output logic        irq,
    output logic [15:0] csr_rd
);

    localparam bit WIDE      = (CNT_W == 32);
    localparam int MATCH_BIT = WIDE ? 15 : 7;
    localparam int OVF_BIT   = 14;
    localparam int IE_BIT    = WIDE ? 5 : 6;
    localparam int CTL_W     = WIDE ? 14 : 7;

    logic [CTL_W-1:0] ctl_q;
    logic             flag_m_q;
    logic             flag_o;

    // Writable control field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (csr_we) begin
            ctl_q <= wr16[CTL_W-1:0];
        end
    end

    // Match flag: a hit sets it and wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_m_q <= 1'b0;
        end else if (hit) begin
            flag_m_q <= 1'b1;
        end else if (csr_we && !wr16[MATCH_BIT]) begin
            flag_m_q <= 1'b0;
        end
    end

    generate
        if (WIDE) begin : g_ovf
            logic flag_o_q;
            // Wrap flag: set by a wrap past all ones, cleared by a write of zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_o_q <= 1'b0;
                end else if (wrap) begin
                    flag_o_q <= 1'b1;
                end else if (csr_we && !wr16[OVF_BIT]) begin
                    flag_o_q <= 1'b0;
                end
            end
            assign flag_o = flag_o_q;

            // R6
            ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wrap |=> flag_o_q);
        end else begin : g_no_ovf
            assign flag_o = 1'b0;
            logic ovf_unused;
            assign ovf_unused = ^{wrap, wr16[15:8]};
        end
    endgenerate

    // Run bit: takes only this channel's position of the shared register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (shr_we) begin
            run <= wr16[CH_IDX];
        end
    end

    // Read image of control/status.
    always_comb begin
        csr_rd            = '0;
        csr_rd[CTL_W-1:0] = ctl_q;
        csr_rd[MATCH_BIT] = flag_m_q;
        csr_rd[OVF_BIT]   = flag_o;
    end

    assign cks = ctl_q[1:0];
    assign irq = flag_m_q && ctl_q[IE_BIT];

    // R7
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_m_q) |-> $past(hit));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_m_q);

    // R7
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_m_q) |-> $past(csr_we));

    // R8
    irq_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !csr_we |=> irq);

endmodule

// File: rtl/cmt_channel.sv
// Compare-match timer channel top: bus decode, read mux and the three
// sub-blocks (prescaler, counter pair, control/status).
// Assumes: reads are combinational on the address. ADDR_W >= SHIFT + 2.
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CH_IDX = 0,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_shr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int SHIFT = (CNT_W == 32) ? 2 : 1;
    localparam int PRE_W = 9;

    cmt_sel_e         sel;
    logic             csr_we, cnt_we, cmp_we, shr_we;
    logic             run, tick, hit, wrap;
    logic [1:0]       cks;
    logic [15:0]      csr_rd;
    logic [CNT_W-1:0] cnt_q, cmp_q;

    // Word-index decode from the byte offset.
    always_comb begin
        sel = cmt_sel_e'(bus_addr[SHIFT+1:SHIFT]);
    end

    assign shr_we = bus_wr && bus_shr;
    assign csr_we = bus_wr && !bus_shr && (sel == SEL_CTRL);
    assign cnt_we = bus_wr && !bus_shr && (sel == SEL_COUNT);
    assign cmp_we = bus_wr && !bus_shr && (sel == SEL_MATCH);

    cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .cks  (cks),
        .tick (tick)
    );

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt_we(cnt_we),
        .cmp_we(cmp_we),
        .wr_val(bus_wdata[CNT_W-1:0]),
        .cnt_q (cnt_q),
        .cmp_q (cmp_q),
        .hit   (hit),
        .wrap  (wrap)
    );

    cmt_ctrl #(.CNT_W(CNT_W), .CH_IDX(CH_IDX)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .csr_we(csr_we),
        .shr_we(shr_we),
        .wr16  (bus_wdata[15:0]),
        .hit   (hit),
        .wrap  (wrap),
        .run   (run),
        .cks   (cks),
        .irq   (irq),
        .csr_rd(csr_rd)
    );

    // Read mux: shared run bit or the selected channel register.
    always_comb begin
        if (bus_shr) begin
            bus_rdata = 32'(run) << CH_IDX;
        end else begin
            case (sel)
                SEL_CTRL:  bus_rdata = {16'h0000, csr_rd};
                SEL_COUNT: bus_rdata = 32'(cnt_q);
                SEL_MATCH: bus_rdata = 32'(cmp_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    logic bus_unused;
    assign bus_unused = ^{bus_addr, bus_wdata};

    // R10
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_we |=> $stable(cnt_q));

    // R4
    run_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shr_we |=> run == $past(bus_wdata[CH_IDX]));

endmodule

// File: tb/sim_cmt_channel.sv
module sim_cmt_channel;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // 16-bit channel, run bit 1
    logic        b0_wr = 1'b0, b0_shr = 1'b0;
    logic [3:0]  b0_addr = '0;
    logic [31:0] b0_wdata = '0, b0_rdata;
    logic        b0_irq;
    // 32-bit channel, run bit 2
    logic        b1_wr = 1'b0, b1_shr = 1'b0;
    logic [3:0]  b1_addr = '0;
    logic [31:0] b1_wdata = '0, b1_rdata;
    logic        b1_irq;

    cmt_channel #(.CNT_W(16), .CH_IDX(1), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(b0_wr), .bus_shr(b0_shr),
        .bus_addr(b0_addr), .bus_wdata(b0_wdata), .bus_rdata(b0_rdata), .irq(b0_irq));

    cmt_channel #(.CNT_W(32), .CH_IDX(2), .ADDR_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(b1_wr), .bus_shr(b1_shr),
        .bus_addr(b1_addr), .bus_wdata(b1_wdata), .bus_rdata(b1_rdata), .irq(b1_irq));

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model of the 16-bit channel
    int m_run, m_pre, m_cnt, m_cmp, m_ctl, m_flag, m_div, m_idx;
    bit m_tk, m_mt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pre = 0; m_cnt = 0; m_cmp = 'hFFFF; m_ctl = 0; m_flag = 0;
        end else begin
            m_div = 8 << (2 * (m_ctl & 3));
            m_tk = 0; m_mt = 0;
            if (m_run != 0) begin
                if (m_pre >= m_div - 1) begin m_tk = 1; m_pre = 0; end
                else m_pre = m_pre + 1;
            end else m_pre = 0;
            m_idx = (int'(b0_addr) >> 1) & 3;
            if (b0_wr && !b0_shr && m_idx == 1) m_cnt = int'(b0_wdata & 32'hFFFF);
            else if (m_tk) begin
                if (m_cnt == m_cmp) begin m_cnt = 0; m_mt = 1; end
                else if (m_cnt == 'hFFFF) m_cnt = 0;
                else m_cnt = m_cnt + 1;
            end
            if (b0_wr && !b0_shr && m_idx == 2) m_cmp = int'(b0_wdata & 32'hFFFF);
            if (b0_wr && !b0_shr && m_idx == 0) begin
                m_ctl = int'(b0_wdata & 32'h7F);
                if (b0_wdata[7] == 1'b0) m_flag = 0;
            end
            if (m_mt) m_flag = 1;
            if (b0_wr && b0_shr) m_run = int'(b0_wdata[1]);
        end
    end

    function automatic int m_read();
        int idx;
        idx = (int'(b0_addr) >> 1) & 3;
        if (b0_shr) return m_run << 1;
        case (idx)
            0: return m_ctl | (m_flag << 7);
            1: return m_cnt;
            2: return m_cmp;
            default: return 0;
        endcase
    endfunction

    // Per-clock comparison, 1 ns after the edge; also the watchdog
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (rst_n) begin
            int exp_rd, exp_irq, idx;
            string tag;
            exp_rd  = m_read();
            exp_irq = ((m_flag != 0) && (((m_ctl >> 6) & 1) != 0)) ? 1 : 0;
            idx = (int'(b0_addr) >> 1) & 3;
            if (b0_shr) tag = "R4 shared read";
            else if (idx == 0) tag = "R7 ctrl/status read";
            else if (idx == 1) tag = "R5 counter read";
            else tag = "R9 compare read";
            chk(b0_rdata == 32'(exp_rd), tag, b0_rdata, exp_rd);
            chk(int'(b0_irq) == exp_irq, "R8 irq", b0_irq, exp_irq);
        end
        if (cyc > 150000 && !done) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wr0(input bit shr, input logic [3:0] a, input logic [31:0] d);
        b0_wr = 1'b1; b0_shr = shr; b0_addr = a; b0_wdata = d;
        @(negedge clk);
        b0_wr = 1'b0; b0_shr = 1'b0;
    endtask

    task automatic idle0(input int n, input logic [3:0] a, input bit shr);
        b0_addr = a; b0_shr = shr;
        repeat (n) @(negedge clk);
        b0_shr = 1'b0;
    endtask

    task automatic wr1(input bit shr, input logic [3:0] a, input logic [31:0] d);
        b1_wr = 1'b1; b1_shr = shr; b1_addr = a; b1_wdata = d;
        @(negedge clk);
        b1_wr = 1'b0; b1_shr = 1'b0;
    endtask

    task automatic rd1(input bit shr, input logic [3:0] a, output logic [31:0] v);
        b1_shr = shr; b1_addr = a;
        #1 v = b1_rdata;
        b1_shr = 1'b0;
    endtask

    initial begin
        logic [31:0] v, held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 word spacing (16-bit: 2 bytes)
        idle0(1, 4'd4, 1'b0);
        chk(b0_rdata == 32'hFFFF, "R1 R2 compare at offset 4", b0_rdata, 32'hFFFF);
        idle0(1, 4'd2, 1'b0);
        chk(b0_rdata == 32'h0, "R1 R2 counter at offset 2", b0_rdata, 0);
        rd1(1'b0, 4'd8, v);
        chk(v == 32'hFFFF_FFFF, "R1 R2 wide compare at offset 8", v, 32'hFFFF_FFFF);
        rd1(1'b0, 4'd0, v);
        chk(v == 32'h0, "R1 wide ctrl/status", v, 0);
        chk(b1_irq == 1'b0, "R1 irq low", b1_irq, 0);

        // 16-bit channel: compare 5, /8, interrupt on, start with junk bits
        wr0(1'b0, 4'd4, 32'd5);
        wr0(1'b0, 4'd0, 32'h40);
        wr0(1'b1, 4'd0, 32'hF2);
        idle0(100, 4'd2, 1'b0);
        idle0(20, 4'd0, 1'b0);
        idle0(5, 4'd0, 1'b1);
        // R7 clearing writes every cycle; some meet a match
        repeat (60) wr0(1'b0, 4'd0, 32'h40);
        // R7 write 1 to flag has no effect
        wr0(1'b0, 4'd0, 32'hC0);
        idle0(10, 4'd0, 1'b0);
        // R9 lower compare below the count: runs on to 0xFFFF
        wr0(1'b0, 4'd2, 32'hFFF0);
        wr0(1'b0, 4'd4, 32'd3);
        idle0(200, 4'd2, 1'b0);
        // R5 slower prescale
        wr0(1'b0, 4'd0, 32'h43);
        wr0(1'b0, 4'd4, 32'd2);
        idle0(4000, 4'd2, 1'b0);
        // R10 stop with other channels' bits set
        wr0(1'b1, 4'd0, 32'hFD);
        idle0(2, 4'd2, 1'b0);
        held = b0_rdata;
        idle0(150, 4'd2, 1'b0);
        chk(b0_rdata == held, "R10 counter holds while stopped", b0_rdata, held);
        // R5 compare zero: match on every tick
        wr0(1'b0, 4'd0, 32'h40);
        wr0(1'b0, 4'd4, 32'd0);
        wr0(1'b1, 4'd0, 32'h02);
        idle0(100, 4'd0, 1'b0);
        idle0(1, 4'd6, 1'b0);

        // 32-bit channel
        wr1(1'b0, 4'd8, 32'hDEADBEEF);
        rd1(1'b0, 4'd8, v);
        chk(v == 32'hDEADBEEF, "R3 wide compare 32-bit", v, 32'hDEADBEEF);
        wr1(1'b0, 4'd0, 32'hABCD_C020);
        rd1(1'b0, 4'd0, v);
        chk(v == 32'h0000_0020, "R3 R7 wide ctrl/status 16-bit, flags not writable", v, 32'h20);
        wr1(1'b0, 4'd4, 32'hFFFF_FFFE);
        wr1(1'b0, 4'd8, 32'h10);
        wr1(1'b1, 4'd0, 32'hFFFF_FFF4);
        rd1(1'b1, 4'd0, v);
        chk(v == 32'h4, "R4 wide shared read", v, 4);
        repeat (40) @(negedge clk);
        rd1(1'b0, 4'd0, v);
        chk(v[14] == 1'b1, "R6 wrap flag bit 14", v[14], 1);
        chk(v[15] == 1'b0, "R6 no match flag yet", v[15], 0);
        chk(b1_irq == 1'b0, "R8 wrap flag gives no irq", b1_irq, 0);
        repeat (200) @(negedge clk);
        rd1(1'b0, 4'd0, v);
        chk(v[15] == 1'b1, "R6 match flag bit 15", v[15], 1);
        chk(b1_irq == 1'b1, "R8 irq with enable bit 5", b1_irq, 1);
        wr1(1'b0, 4'd0, 32'h0000_0020);
        rd1(1'b0, 4'd0, v);
        chk(v == 32'h20, "R7 write zero clears both flags", v, 32'h20);
        chk(b1_irq == 1'b0, "R7 irq drops after clear", b1_irq, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule